// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block interprets the write traffic of a parallel NOR flash that follows the Intel-style command set. Every bus write either starts a command in its first cycle or completes one in its second cycle. The block keeps a one-bit write-cycle counter, the current command byte and an 8-bit status register. The current command decides what a bus read returns: array bytes, the status byte, identifier codes or query table bytes.

Single-word program and sector erase act directly on a small internal byte array. A side port lets a testbench or neighbouring logic look at any byte of that array. A read-only input makes program and erase fail: the array is left alone and sticky error flags are set. Operation timing is not modelled, so every operation is complete in the cycle that its final write is clocked in.

Accesses are word aligned: the low address bits that select a byte inside a bus word are ignored. The command byte is always bus bits [7:0].

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array read mode, and the status byte is 0x00. The array holds 0xFF in every byte.
- R2: In cycle 0, a write of 0x10 or 0x40 arms a program. The next write stores its full bus word at the aligned address, sets status bit 7 and returns the cycle counter to 0. Reads keep returning status until a new command arrives.
- R3: In cycle 0, a write of 0x20 fills the whole sector that contains the address with 0xFF and sets bit 7. The next write may be 0xD0, which confirms and keeps the status read. Any other byte, including 0xFF, returns to array read.
- R4: In cycle 0, a write of 0x50 sets the status byte to 0x00 and selects array read.
- R5: Writes of 0x70 and 0x90 take effect in one cycle, and the cycle counter stays at 0. 0x70 selects status read. 0x90 selects identifier read. Identifier index 0 (the word address, which is the byte address shifted right by log2 of the bus bytes) returns the manufacturer code. Index 1 returns the device code, and any other index returns 0. Each code fills every device lane.
- R6: 0x60 waits for a second byte. A second byte of 0xD0 or 0x01 finishes with bit 7 set and keeps the status read. Any other second byte returns to array read.
- R7: 0x98 enters query mode. A later write of 0xFF leaves it, and any other write keeps it. The query index is the word address, and its byte sits in the low byte of every device lane. Index 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Index 0x27 returns the log2 of the array size. Indexes 0x2D and 0x2E return the number of sectors minus one, low byte first. Indexes 0x2F and 0x30 return bits 15:8 and 23:16 of the sector size. Every other index returns 0.
- R8: In cycle 0, writes of 0x00, 0xF0 and 0xFF, and any byte that is not a known command, select array read with the cycle counter at 0.
- R9: While read-only is asserted, a program sets status bit 4 and an erase sets status bit 5. Neither changes the array, and bit 7 is still set.
- R10: While the current command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte in the low byte of each device-width lane of the bus word.
- R11: Multi-byte reads and writes map byte k of the aligned word to array byte base+k. In little-endian order that byte is word bits [8k+7:8k]. In big-endian order it is the most significant byte first.
- R12: Status bits 5 and 4 stay set until a 0x50 command clears them. Bits 6 and 3 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8*BUS_BYTES | Write word; bits [7:0] carry the command byte |
| bus_we | input | 1 | Write strobe, one write per cycle |
| ro_lock | input | 1 | Storage is read-only |
| bus_rdata | output | 8*BUS_BYTES | Read word for bus_addr under the current command |
| peek_addr | input | ADDR_W | Byte address for the array inspection port |
| peek_byte | output | 8 | Array byte at peek_addr |

## Verification
The bench builds the block with a 2-byte bus, 1-byte device lanes, a 256-byte array in 32-byte sectors and big-endian order. With these values each read carries two replicated lanes. Byte order is visible in every program, sectors are small enough that random erases often cross data already programmed, and the query index reaches the size fields at 0x27 and 0x2D. Random command streams that mix valid bytes, confirm, abort and junk bytes with random toggling of read-only are compared against a bench model after every write.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int BUS_BYTES  = 2,
  parameter int DEV_BYTES  = 1,
  parameter int ADDR_W     = 8,
  parameter int SECT_W     = 5,
  parameter bit BIG_ENDIAN = 0,
  parameter logic [31:0] MFR_CODE = 32'h0000_0089,
  parameter logic [31:0] DEV_CODE = 32'h0000_0018
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [8*BUS_BYTES-1:0] bus_wdata,
  input  logic                   bus_we,
  input  logic                   ro_lock,
  output logic [8*BUS_BYTES-1:0] bus_rdata,
  input  logic [ADDR_W-1:0]      peek_addr,
  output logic [7:0]             peek_byte
);
  localparam int BW         = 8 * BUS_BYTES;
  localparam int DW         = 8 * DEV_BYTES;
  localparam int LANES      = BUS_BYTES / DEV_BYTES;
  localparam int ALIGN      = $clog2(BUS_BYTES);
  localparam int NBYTES     = 1 << ADDR_W;
  localparam int SECT_BYTES = 1 << SECT_W;
  localparam int NSECT      = 1 << (ADDR_W - SECT_W);
  localparam logic [31:0] SECT_LAST = 32'(NSECT - 1);
  localparam logic [31:0] SECT_SIZE = 32'(SECT_BYTES);

  logic [7:0] mem [NBYTES];
  logic [7:0] cmd_q;
  logic       cyc_q;
  logic [7:0] stat_q;

  wire [7:0]        cb       = bus_wdata[7:0];
  wire [ADDR_W-1:0] base     = bus_addr & ~ADDR_W'(BUS_BYTES - 1);
  wire [ADDR_W-1:0] word_idx = bus_addr >> ALIGN;
  wire              prog_cmd = (cmd_q == 8'h10) || (cmd_q == 8'h40);
  wire              do_prog  = bus_we && cyc_q && prog_cmd;
  wire              do_erase = bus_we && !cyc_q && (cb == 8'h20);

  assign peek_byte = mem[peek_addr];

  function automatic logic [7:0] wbyte(int k);
    return BIG_ENDIAN ? bus_wdata[8*(BUS_BYTES-1-k) +: 8] : bus_wdata[8*k +: 8];
  endfunction

  function automatic logic stat_mode(logic [7:0] c);
    case (c)
      8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] qry_byte(logic [ADDR_W-1:0] ix);
    case (32'(ix))
      32'h10: return 8'h51;
      32'h11: return 8'h52;
      32'h12: return 8'h59;
      32'h27: return 8'(ADDR_W);
      32'h2D: return SECT_LAST[7:0];
      32'h2E: return SECT_LAST[15:8];
      32'h2F: return SECT_SIZE[15:8];
      32'h30: return SECT_SIZE[23:16];
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else if (do_prog && !ro_lock) begin
      for (int k = 0; k < BUS_BYTES; k++) mem[base + ADDR_W'(k)] <= wbyte(k);
    end else if (do_erase && !ro_lock) begin
      for (int i = 0; i < NBYTES; i++)
        if ((ADDR_W'(i) >> SECT_W) == (bus_addr >> SECT_W)) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 8'h00;
      cyc_q  <= 1'b0;
      stat_q <= 8'h00;
    end else if (bus_we) begin
      if (!cyc_q) begin
        case (cb)
          8'h10, 8'h40, 8'h60, 8'h98: begin
            cmd_q <= cb;
            cyc_q <= 1'b1;
          end
          8'h20: begin
            cmd_q  <= cb;
            cyc_q  <= 1'b1;
            stat_q <= stat_q | 8'h80 | (ro_lock ? 8'h20 : 8'h00);
          end
          8'h50: begin
            stat_q <= 8'h00;
            cmd_q  <= 8'h00;
          end
          8'h70, 8'h90: cmd_q <= cb;
          default: cmd_q <= 8'h00;
        endcase
      end else begin
        case (cmd_q)
          8'h10, 8'h40: begin
            stat_q <= stat_q | 8'h80 | (ro_lock ? 8'h10 : 8'h00);
            cyc_q  <= 1'b0;
          end
          8'h20: begin
            cyc_q <= 1'b0;
            if (cb == 8'hD0) stat_q <= stat_q | 8'h80;
            else cmd_q <= 8'h00;
          end
          8'h60: begin
            cyc_q <= 1'b0;
            if (cb == 8'hD0 || cb == 8'h01) stat_q <= stat_q | 8'h80;
            else cmd_q <= 8'h00;
          end
          8'h98: begin
            if (cb == 8'hFF) begin
              cmd_q <= 8'h00;
              cyc_q <= 1'b0;
            end
          end
          default: begin
            cmd_q <= 8'h00;
            cyc_q <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (cmd_q == 8'h00) begin
      for (int k = 0; k < BUS_BYTES; k++)
        if (BIG_ENDIAN) bus_rdata[8*(BUS_BYTES-1-k) +: 8] = mem[base + ADDR_W'(k)];
        else            bus_rdata[8*k +: 8]               = mem[base + ADDR_W'(k)];
    end else if (stat_mode(cmd_q)) begin
      for (int l = 0; l < LANES; l++) bus_rdata[DW*l +: DW] = DW'(stat_q);
    end else if (cmd_q == 8'h90) begin
      for (int l = 0; l < LANES; l++)
        bus_rdata[DW*l +: DW] = (word_idx == '0)           ? MFR_CODE[DW-1:0] :
                                (word_idx == ADDR_W'(1))   ? DEV_CODE[DW-1:0] : '0;
    end else if (cmd_q == 8'h98) begin
      for (int l = 0; l < LANES; l++) bus_rdata[DW*l +: DW] = DW'(qry_byte(word_idx));
    end
  end

  a_r12_sticky_erase_err: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[5] && !(bus_we && !cyc_q && cb == 8'h50)) |=> stat_q[5]);
  a_r12_sticky_prog_err: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[4] && !(bus_we && !cyc_q && cb == 8'h50)) |=> stat_q[4]);
  a_r2_ready_after_prog: assert property (@(posedge clk) disable iff (!rst_n)
    do_prog |=> (stat_q[7] && !cyc_q));
  a_r9_ro_prog_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (do_prog && ro_lock) |=> stat_q[4]);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !cyc_q && (cb == 8'h70 || cb == 8'h90)) |=> (!cyc_q && cmd_q == $past(cb)));
  a_r8_ff_to_array: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !cyc_q && cb == 8'hFF) |=> (cmd_q == 8'h00 && !cyc_q));
  a_r7_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && cyc_q && cmd_q == 8'h98 && cb != 8'hFF) |=> cmd_q == 8'h98);
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int BB = 2, DB = 1, AW = 8, SW = 5;
  localparam int NB = 1 << AW;

  logic clk = 0, rst_n = 0, bus_we = 0, ro_lock = 0;
  logic [AW-1:0] bus_addr = '0, peek_addr = '0;
  logic [8*BB-1:0] bus_wdata = '0, bus_rdata;
  logic [7:0] peek_byte;
  int vec = 0, bad = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.BUS_BYTES(BB), .DEV_BYTES(DB), .ADDR_W(AW), .SECT_W(SW),
                  .BIG_ENDIAN(1)) dut (.*);

  logic [7:0] m [NB];
  logic [7:0] st, mcmd;
  bit mcyc;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] qx(int ix);
    case (ix)
      'h10: return 8'h51; 'h11: return 8'h52; 'h12: return 8'h59;
      'h27: return 8'(AW);
      'h2D: return 8'((NB >> SW) - 1);
      'h2E: return 8'(((NB >> SW) - 1) >> 8);
      'h2F: return 8'((1 << SW) >> 8);
      'h30: return 8'((1 << SW) >> 16);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [8*BB-1:0] exp_read(logic [AW-1:0] a);
    logic [8*BB-1:0] r = '0;
    int b = int'(a) & ~(BB - 1);
    int ix = int'(a) / BB;
    case (mcmd)
      8'h00: for (int k = 0; k < BB; k++) r[8*(BB-1-k) +: 8] = m[(b + k) % NB];
      8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8:
        for (int l = 0; l < BB/DB; l++) r[8*DB*l +: 8*DB] = (8*DB)'(st);
      8'h90: for (int l = 0; l < BB/DB; l++)
        r[8*DB*l +: 8*DB] = (ix == 0) ? 8'h89 : (ix == 1) ? 8'h18 : 8'h00;
      8'h98: for (int l = 0; l < BB/DB; l++) r[8*DB*l +: 8*DB] = (8*DB)'(qx(ix));
      default: r = 'x;
    endcase
    return r;
  endfunction

  task automatic model_wr(logic [AW-1:0] a, logic [8*BB-1:0] d);
    logic [7:0] c = d[7:0];
    int b = int'(a) & ~(BB - 1);
    if (!mcyc) begin
      case (c)
        8'h10, 8'h40, 8'h60, 8'h98: begin mcmd = c; mcyc = 1; end
        8'h20: begin
          if (ro_lock) st |= 8'h20;
          else for (int i = 0; i < NB; i++) if ((i >> SW) == (int'(a) >> SW)) m[i] = 8'hFF;
          st |= 8'h80; mcmd = c; mcyc = 1;
        end
        8'h50: begin st = 0; mcmd = 0; end
        8'h70, 8'h90: mcmd = c;
        default: mcmd = 0;
      endcase
    end else begin
      case (mcmd)
        8'h10, 8'h40: begin
          if (ro_lock) st |= 8'h10;
          else for (int k = 0; k < BB; k++) m[(b + k) % NB] = d[8*(BB-1-k) +: 8];
          st |= 8'h80; mcyc = 0;
        end
        8'h20: begin mcyc = 0; if (c == 8'hD0) st |= 8'h80; else mcmd = 0; end
        8'h60: begin mcyc = 0; if (c == 8'hD0 || c == 8'h01) st |= 8'h80; else mcmd = 0; end
        8'h98: if (c == 8'hFF) begin mcmd = 0; mcyc = 0; end
        default: begin mcmd = 0; mcyc = 0; end
      endcase
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [8*BB-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    model_wr(a, d);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(string tag, logic [AW-1:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    check(tag, 32'(bus_rdata), exp);
  endtask

  task automatic pk(string tag, logic [AW-1:0] a, logic [7:0] exp);
    peek_addr = a; #1;
    check(tag, 32'(peek_byte), 32'(exp));
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NB; i++) m[i] = 8'hFF;
    st = 0; mcmd = 0; mcyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R1 array after reset", 8'h00, 32'hFFFF);
    wr(0, 16'h0070);
    rd("R1 status after reset", 8'h00, 32'h0000);

    wr(0, 16'h0040); wr(8'h11, 16'h1234);
    rd("R10 status lanes after program", 8'h11, 32'h8080);
    pk("R11 big-endian first byte", 8'h10, 8'h12);
    pk("R11 big-endian second byte", 8'h11, 8'h34);
    wr(0, 16'h00FF);
    rd("R2 programmed word", 8'h10, 32'h1234);
    wr(0, 16'h0010); wr(8'h50, 16'hA55A);
    wr(0, 16'h00F0);
    rd("R2 program via 0x10", 8'h50, 32'hA55A);

    wr(8'h1E, 16'h0020);
    rd("R3 status during erase", 8'h00, 32'h8080);
    wr(0, 16'h00D0);
    pk("R3 sector erased", 8'h10, 8'hFF);
    pk("R3 other sector kept", 8'h50, 8'hA5);
    wr(8'h40, 16'h0020); wr(0, 16'h0055);
    rd("R3 bad confirm to array read", 8'h50, 32'hFFFF);

    ro_lock = 1;
    wr(0, 16'h0010); wr(8'h60, 16'hBEEF);
    rd("R9 read-only program flags", 8'h00, 32'h9090);
    pk("R9 array untouched by program", 8'h60, 8'hFF);
    wr(0, 16'h0040); wr(8'h62, 16'h0000);
    wr(8'h62, 16'h0020); wr(0, 16'h00D0);
    rd("R9 read-only erase flags", 8'h00, 32'hB0B0);
    ro_lock = 0;
    wr(0, 16'h00FF); wr(0, 16'h0070);
    rd("R12 errors sticky", 8'h00, 32'hB0B0);
    wr(0, 16'h0050);
    rd("R4 clear returns to array", 8'h04, 32'hFFFF);
    wr(0, 16'h0070);
    rd("R4 status cleared", 8'h00, 32'h0000);

    wr(0, 16'h0090);
    rd("R5 manufacturer code", 8'h00, 32'h8989);
    rd("R5 device code", 8'h02, 32'h1818);
    rd("R5 other index zero", 8'h04, 32'h0000);

    wr(0, 16'h0060); wr(0, 16'h0001);
    rd("R6 lock confirm ready", 8'h00, 32'h8080);
    wr(0, 16'h0060); wr(0, 16'h0033);
    rd("R6 bad second byte to array", 8'h50, 32'hFFFF);

    wr(0, 16'h0098);
    rd("R7 query Q", 8'h20, 32'h5151);
    wr(0, 16'h0012);
    rd("R7 query kept, R", 8'h22, 32'h5252);
    rd("R7 sector count", 8'h5A, 32'h0707);
    rd("R7 size field", 8'h4E, 32'h0808);
    wr(0, 16'h00FF);
    rd("R7 FF leaves query", 8'h00, 32'hFFFF);

    wr(0, 16'h0070); wr(0, 16'h0077);
    rd("R8 unknown byte to array", 8'h50, 32'hFFFF);
    wr(0, 16'h0070); wr(0, 16'h0000);
    rd("R8 0x00 to array", 8'h50, 32'hFFFF);

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] pool [14] = '{8'h00, 8'h10, 8'h20, 8'h40, 8'h50, 8'h60, 8'h70,
                                8'h90, 8'h98, 8'hD0, 8'h01, 8'hFF, 8'hF0, 8'h00};
      logic [15:0] d = 16'($urandom);
      logic [AW-1:0] a = AW'($urandom);
      if ($urandom_range(15) == 0) ro_lock = ~ro_lock;
      if ($urandom_range(3) != 0) d[7:0] = pool[$urandom_range(12)];
      wr(a, d);
      a = AW'($urandom);
      rd("R10 R11 random read vs model", a, 32'(exp_read(a)));
      if (n % 8 == 0) pk("R3 R2 random peek vs model", a, m[a]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule